// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Unit

This unit sits beside a shared memory with two access ports, a left one and a right one, and turns two fixed words at the very top of the address space into doorbells. Each port owns one outgoing mailbox word. When a port writes its outgoing word, the peer port receives an active-low interrupt. The peer acknowledges by reading that same word, which removes the interrupt. The bytes themselves are held by the ordinary memory array, which is outside this unit; the unit only watches each port's select, output-enable, write-strobe and address lines, plus the busy qualifier that the arbitration logic hands each port.

The left port's outgoing word is the highest address (all ones, 0x1FFF for the default 13-bit address). The right port's outgoing word is one below it (0x1FFE). Software that does not use the doorbells can treat both words as normal storage: the unit never alters data, it only produces the two interrupt outputs.

All port inputs are sampled on the rising clock edge; an interrupt output changes on the edge that samples the access that moves it.

Top module: `mbx_irq_unit`

## Requirements
- R1: While and after synchronous reset (`rst` high at a rising edge), both `lf_irq_n` and `rt_irq_n` are high (inactive).
- R2: A left write (`lf_sel_n`=0, `lf_wr_n`=0, `lf_busy_n`=1) to address all-ones (0x1FFF) drives `rt_irq_n` low from the following edge.
- R3: A right read (`rt_sel_n`=0, `rt_oe_n`=0, `rt_wr_n`=1) of address all-ones (0x1FFF) returns `rt_irq_n` high from the following edge.
- R4: A right write (`rt_sel_n`=0, `rt_wr_n`=0, `rt_busy_n`=1) to address all-ones minus one (0x1FFE) drives `lf_irq_n` low from the following edge.
- R5: A left read (`lf_sel_n`=0, `lf_oe_n`=0, `lf_wr_n`=1) of address 0x1FFE returns `lf_irq_n` high from the following edge.
- R6: A write to a port's outgoing mailbox while that port's busy input is low (active) leaves the peer's interrupt output unchanged.
- R7: If the same cycle holds both a setting write and a clearing read for one interrupt, the interrupt ends up low (set wins).
- R8: An access counts only when qualified: a write needs select and write strobe both low, a read needs select and output enable both low with write strobe high; unqualified cycles, accesses to any other address, a receiver writing its incoming word, and a sender reading its outgoing word leave both outputs unchanged.
- R9: With no setting or clearing access, each interrupt output keeps its value across cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lf_sel_n | input | 1 | Left port select, active low |
| lf_oe_n | input | 1 | Left port output enable, active low |
| lf_wr_n | input | 1 | Left port write strobe, active low |
| lf_addr | input | ADDR_W | Left port address |
| lf_busy_n | input | 1 | Left port busy from arbiter, active low, blocks left writes |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_wr_n | input | 1 | Right port write strobe, active low |
| rt_addr | input | ADDR_W | Right port address |
| rt_busy_n | input | 1 | Right port busy from arbiter, active low, blocks right writes |
| lf_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The assertions take for granted that every port input is a known level at each rising edge once reset has been released and that it is stable across that edge, as a synchronous front end would present it. The stimulus respects this by changing inputs only just after a falling edge and returning each port to an idle, deselected state between scenarios. Busy is driven only as a plain level per cycle, never glitched inside a cycle, so the write-block property sees the same qualifier that the flag logic saw.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;

    function automatic acc_kind_e classify(input logic sel_n,
                                           input logic oe_n,
                                           input logic wr_n);
        acc_kind_e k;
        if (sel_n)
            k = ACC_IDLE;
        else if (!wr_n)
            k = ACC_WRITE;
        else if (!oe_n)
            k = ACC_READ;
        else
            k = ACC_IDLE;
        return k;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int PORT_IDX = 0
) (
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              notify,
    output logic              ack
);
    localparam logic [ADDR_W-1:0] SLOT_HI = '1;
    localparam logic [ADDR_W-1:0] SLOT_LO = SLOT_HI - 1'b1;
    localparam logic [ADDR_W-1:0] OUT_SLOT = (PORT_IDX == 0) ? SLOT_HI : SLOT_LO;
    localparam logic [ADDR_W-1:0] IN_SLOT  = (PORT_IDX == 0) ? SLOT_LO : SLOT_HI;

    acc_kind_e kind;

    always_comb begin
        kind   = classify(sel_n, oe_n, wr_n);
        notify = (kind == ACC_WRITE) && (addr == OUT_SLOT) && busy_n;
        ack    = (kind == ACC_READ)  && (addr == IN_SLOT);
    end

    // R8: a port never rings and acknowledges in the same cycle
    always_comb begin
        p_excl_r8: assert (!(notify && ack));
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_req_t req,
    output logic      irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (req.set)
            pending <= 1'b1;
        else if (req.clr)
            pending <= 1'b0;
    end

    assign irq_n = ~pending;

    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        req.set |=> !irq_n);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (req.clr && !req.set) |=> irq_n);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!req.set && !req.clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_sel_n,
    input  logic              lf_oe_n,
    input  logic              lf_wr_n,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic              lf_busy_n,
    input  logic              rt_sel_n,
    input  logic              rt_oe_n,
    input  logic              rt_wr_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy_n,
    output logic              lf_irq_n,
    output logic              rt_irq_n
);
    localparam int NPORT = 2;

    logic              sel_n_a  [NPORT];
    logic              oe_n_a   [NPORT];
    logic              wr_n_a   [NPORT];
    logic [ADDR_W-1:0] addr_a   [NPORT];
    logic              busy_n_a [NPORT];
    logic              notify_a [NPORT];
    logic              ack_a    [NPORT];
    logic              irq_n_a  [NPORT];

    assign sel_n_a[0]  = lf_sel_n;
    assign oe_n_a[0]   = lf_oe_n;
    assign wr_n_a[0]   = lf_wr_n;
    assign addr_a[0]   = lf_addr;
    assign busy_n_a[0] = lf_busy_n;
    assign sel_n_a[1]  = rt_sel_n;
    assign oe_n_a[1]   = rt_oe_n;
    assign wr_n_a[1]   = rt_wr_n;
    assign addr_a[1]   = rt_addr;
    assign busy_n_a[1] = rt_busy_n;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        flag_req_t req;

        mbx_port_decode #(.ADDR_W(ADDR_W), .PORT_IDX(p)) u_dec (
            .sel_n  (sel_n_a[p]),
            .oe_n   (oe_n_a[p]),
            .wr_n   (wr_n_a[p]),
            .addr   (addr_a[p]),
            .busy_n (busy_n_a[p]),
            .notify (notify_a[p]),
            .ack    (ack_a[p])
        );

        // flag p is rung by the opposite port, acknowledged by port p
        assign req.set = notify_a[NPORT-1-p];
        assign req.clr = ack_a[p];

        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .req   (req),
            .irq_n (irq_n_a[p])
        );
    end

    assign lf_irq_n = irq_n_a[0];
    assign rt_irq_n = irq_n_a[1];

    localparam logic [ADDR_W-1:0] TOP_A = '1;
    localparam logic [ADDR_W-1:0] NXT_A = TOP_A - 1'b1;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (lf_irq_n && rt_irq_n));
    p_ring_right_r2: assert property (@(posedge clk) disable iff (rst)
        (!lf_sel_n && !lf_wr_n && lf_busy_n && lf_addr == TOP_A) |=> !rt_irq_n);
    p_ring_left_r4: assert property (@(posedge clk) disable iff (rst)
        (!rt_sel_n && !rt_wr_n && rt_busy_n && rt_addr == NXT_A) |=> !lf_irq_n);
    p_ack_left_r5: assert property (@(posedge clk) disable iff (rst)
        (!lf_sel_n && !lf_oe_n && lf_wr_n && lf_addr == NXT_A && lf_irq_n == 1'b0
         && !(!rt_sel_n && !rt_wr_n && rt_busy_n && rt_addr == NXT_A)) |=> lf_irq_n);
    p_busy_block_r6: assert property (@(posedge clk) disable iff (rst)
        (!lf_busy_n && rt_irq_n) |=> rt_irq_n);
    p_busy_block_rt_r6: assert property (@(posedge clk) disable iff (rst)
        (!rt_busy_n && lf_irq_n) |=> lf_irq_n);

endmodule

// File: tb/mbx_irq_unit_bench.sv
`timescale 1ns/1ps
module mbx_irq_unit_bench;
    localparam int AW = 13;
    localparam logic [AW-1:0] HI = 13'h1FFF;
    localparam logic [AW-1:0] LO = 13'h1FFE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lf_sel_n = 1, lf_oe_n = 1, lf_wr_n = 1, lf_busy_n = 1;
    logic rt_sel_n = 1, rt_oe_n = 1, rt_wr_n = 1, rt_busy_n = 1;
    logic [AW-1:0] lf_addr = '0, rt_addr = '0;
    logic lf_irq_n, rt_irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mbx_irq_unit #(.ADDR_W(AW)) u_mbx_irq_unit (
        .clk(clk), .rst(rst),
        .lf_sel_n(lf_sel_n), .lf_oe_n(lf_oe_n), .lf_wr_n(lf_wr_n),
        .lf_addr(lf_addr), .lf_busy_n(lf_busy_n),
        .rt_sel_n(rt_sel_n), .rt_oe_n(rt_oe_n), .rt_wr_n(rt_wr_n),
        .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
        .lf_irq_n(lf_irq_n), .rt_irq_n(rt_irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_all();
        lf_sel_n = 1; lf_oe_n = 1; lf_wr_n = 1; lf_busy_n = 1;
        rt_sel_n = 1; rt_oe_n = 1; rt_wr_n = 1; rt_busy_n = 1;
    endtask

    // apply current inputs for one rising edge, then idle; sample at falling edge
    task automatic step();
        @(negedge clk);
        idle_all();
    endtask

    task automatic lf_acc(input bit wr, input logic [AW-1:0] a);
        lf_sel_n = 0; lf_addr = a;
        if (wr) begin lf_wr_n = 0; lf_oe_n = 1; end
        else    begin lf_wr_n = 1; lf_oe_n = 0; end
    endtask

    task automatic rt_acc(input bit wr, input logic [AW-1:0] a);
        rt_sel_n = 0; rt_addr = a;
        if (wr) begin rt_wr_n = 0; rt_oe_n = 1; end
        else    begin rt_wr_n = 1; rt_oe_n = 0; end
    endtask

    task automatic t_reset();
        rst = 1;
        lf_acc(1, HI); rt_acc(1, LO);
        repeat (3) @(negedge clk);
        check("R1 lf_irq_n in reset", lf_irq_n, 1'b1);
        check("R1 rt_irq_n in reset", rt_irq_n, 1'b1);
        idle_all();
        rst = 0;
        @(negedge clk);
        check("R1 lf_irq_n after reset", lf_irq_n, 1'b1);
        check("R1 rt_irq_n after reset", rt_irq_n, 1'b1);
    endtask

    task automatic t_left_rings_right();
        lf_acc(1, HI); step();
        check("R2 rt_irq_n set", rt_irq_n, 1'b0);
        check("R2 lf_irq_n untouched", lf_irq_n, 1'b1);
        repeat (4) @(negedge clk);
        check("R9 rt_irq_n held", rt_irq_n, 1'b0);
        rt_acc(0, HI); step();
        check("R3 rt_irq_n cleared", rt_irq_n, 1'b1);
    endtask

    task automatic t_right_rings_left();
        rt_acc(1, LO); step();
        check("R4 lf_irq_n set", lf_irq_n, 1'b0);
        check("R4 rt_irq_n untouched", rt_irq_n, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 lf_irq_n held", lf_irq_n, 1'b0);
        lf_acc(0, LO); step();
        check("R5 lf_irq_n cleared", lf_irq_n, 1'b1);
        repeat (2) @(negedge clk);
        check("R9 lf_irq_n stays clear", lf_irq_n, 1'b1);
    endtask

    task automatic t_busy();
        lf_acc(1, HI); lf_busy_n = 0; step();
        check("R6 left busy blocks ring", rt_irq_n, 1'b1);
        rt_acc(1, LO); rt_busy_n = 0; step();
        check("R6 right busy blocks ring", lf_irq_n, 1'b1);
        // busy on the other port does not block
        lf_acc(1, HI); rt_busy_n = 0; step();
        check("R6 peer busy does not block", rt_irq_n, 1'b0);
        rt_acc(0, HI); step();
        check("R3 clear after busy test", rt_irq_n, 1'b1);
    endtask

    task automatic t_qualify();
        lf_acc(1, HI); lf_sel_n = 1; step();
        check("R8 deselected write ignored", rt_irq_n, 1'b1);
        lf_acc(1, 13'h1FFD); step();
        check("R8 other address ignored", rt_irq_n, 1'b1);
        lf_acc(1, 13'h0FFF); step();
        check("R8 low alias ignored", rt_irq_n, 1'b1);
        rt_acc(1, HI); step();
        check("R8 receiver write of own word ignored", rt_irq_n, 1'b1);
        lf_acc(0, HI); step();
        check("R8 sender read ignored", rt_irq_n, 1'b1);
        lf_acc(1, HI); step();
        check("R2 ring for qualifier tests", rt_irq_n, 1'b0);
        rt_acc(0, HI); rt_oe_n = 1; step();
        check("R8 read without oe ignored", rt_irq_n, 1'b0);
        rt_acc(0, HI); rt_sel_n = 1; step();
        check("R8 read without select ignored", rt_irq_n, 1'b0);
        rt_acc(0, LO); step();
        check("R8 read of wrong word ignored", rt_irq_n, 1'b0);
        rt_acc(1, HI); step();
        check("R8 write is not acknowledge", rt_irq_n, 1'b0);
        rt_acc(1, HI); rt_oe_n = 0; step();
        check("R8 write with oe low is not read", rt_irq_n, 1'b0);
        rt_acc(0, HI); step();
        check("R3 clear after qualifier tests", rt_irq_n, 1'b1);
    endtask

    task automatic t_collision();
        lf_acc(1, HI); rt_acc(0, HI); step();
        check("R7 set wins from clear state (right)", rt_irq_n, 1'b0);
        lf_acc(1, HI); rt_acc(0, HI); step();
        check("R7 set wins from set state (right)", rt_irq_n, 1'b0);
        rt_acc(0, HI); step();
        check("R3 clear after collision", rt_irq_n, 1'b1);
        rt_acc(1, LO); step();
        check("R4 ring before collision", lf_irq_n, 1'b0);
        rt_acc(1, LO); lf_acc(0, LO); step();
        check("R7 set wins (left)", lf_irq_n, 1'b0);
        lf_acc(0, LO); step();
        check("R5 clear after collision", lf_irq_n, 1'b1);
        check("R9 right idle through left collision", rt_irq_n, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_left_rings_right();
        t_right_rings_left();
        t_busy();
        t_qualify();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule